// File: doc/BRIEF.md
# LED Diagnostic Mode Sequencer

This block is the control core of a chained constant-current LED driver that can run diagnostics. It watches four serial-side inputs: the shift clock, the load strobe, the active-low output enable and the serial data input. From them it decides whether the driver is in normal display operation or in fault-diagnosis operation. In diagnosis operation it counts shift-clock pulses given while the load strobe is held high. The count picks the open-LED report, the shorted-LED report or reduced-current testing. With no pulses, only the global check is active.

During the global check the block forms a chain fault flag. The flag is the upstream serial input ANDed with the local no-fault status, so a string of drivers carries a single pass/fail bit to its last device. Reduced-current testing is set up in steps. A load pulse first requests that an all-ones test pattern be put into the shift register. Reduced current then follows the output enable: it is applied while the enable is low and dropped on the cycle the enable returns high. In normal operation the block also takes power commands from the serial input. While the device is powered down it blocks data-register updates and the output drivers.

All inputs are treated as synchronous to the block clock. Edges are found by comparing each input with its value on the previous clock.

Top module: `ledDiagSeq`

## Requirements
- R1: A rising edge of loadStrobe while outEnN is high enters diagnosis operation on the next clock (errActive = 1), with the pulse count cleared so that no report select is asserted.
- R2: In diagnosis operation, each rising serClk edge seen while loadStrobe is high adds one to the pulse count. A count of 1 asserts openSel, 2 asserts shortSel and 3 asserts lowCurSel. Further pulses leave the count at 3.
- R3: At most one of openSel, shortSel and lowCurSel is high at any time, and none is high outside diagnosis operation.
- R4: While in diagnosis operation with a pulse count of 0, chainOut equals serIn AND NOT localFault in the same cycle (0 = a fault somewhere up the chain or here, 1 = none). At all other times chainOut is 1.
- R5: After loadStrobe has fallen with a count of 0, 1 or 2, outEnN low returns the block to normal operation on the next clock with no report read. This clears errActive and every select.
- R6: After loadStrobe falls with the count at 3, the next rising loadStrobe edge gives a patternLoad pulse that is exactly one clock long.
- R7: After that pattern load, lowCurrent is 1 in every cycle outEnN is low. On the cycle outEnN rises, lowCurrent drops at once, and diagnosis operation ends on the next clock.
- R8: In normal operation, a rising serClk edge seen while loadStrobe is high and outEnN is low samples serIn. A 0 sets shutdown on the next clock and a 1 clears it.
- R9: In normal operation, a rising loadStrobe edge with outEnN low gives a one-clock dataLatch pulse, and driveEn equals NOT outEnN. While shutdown is 1, dataLatch stays 0 and driveEn stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial shift clock (sampled) |
| loadStrobe | input | 1 | Load strobe (sampled) |
| outEnN | input | 1 | Active-low output enable (sampled) |
| serIn | input | 1 | Serial data / upstream chain flag |
| localFault | input | 1 | Local fault present (1 = fault) |
| errActive | output | 1 | Diagnosis operation active |
| openSel | output | 1 | Open-LED report selected |
| shortSel | output | 1 | Shorted-LED report selected |
| lowCurSel | output | 1 | Reduced-current testing selected |
| lowCurrent | output | 1 | Reduced current request to the drivers |
| patternLoad | output | 1 | One-clock request to fill the shift register with ones |
| chainOut | output | 1 | Chain fault flag (0 = fault) |
| dataLatch | output | 1 | One-clock data-register update strobe |
| driveEn | output | 1 | Output driver enable |
| shutdown | output | 1 | Powered-down state |

## Verification
The assertions assume that each input is held for at least one clock between changes. This lets every edge be seen as a single-cycle event. They also assume that serClk and loadStrobe are not toggled in the same cycle. The stimulus changes only one input per falling clock edge and always waits a full clock before the next change. Pulses on serClk are given only while loadStrobe is settled high. A power command is given only with outEnN already low, so it cannot be mistaken for entry into diagnosis operation.

// File: rtl/ledDiagPkg.sv
package ledDiagPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_HOLD,
    ST_LC_ARM,
    ST_LC_RUN
  } diagState_t;

  typedef struct packed {
    logic enterErr;
    logic pulse;
    logic leaveErr;
    logic patLoad;
    logic latch;
    logic shutReq;
    logic wakeReq;
  } ctrlStrobe_t;

endpackage

// File: rtl/ledDiagEdge.sv
module ledDiagEdge #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  logic [N-1:0] prevSig;

  for (genvar g = 0; g < N; g++) begin : gBit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prevSig[g] <= RST_VAL[g];
      else       prevSig[g] <= sig[g];
    end
    assign rise[g] = sig[g] & ~prevSig[g];
    assign fall[g] = ~sig[g] & prevSig[g];
  end

endmodule

// File: rtl/ledDiagCtrl.sv
module ledDiagCtrl
  import ledDiagPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        loadStrobe,
  input  logic        outEnN,
  input  logic        serIn,
  input  logic        lcSelected,
  output ctrlStrobe_t strb,
  output logic        errActive,
  output logic        lowCurrent
);

  localparam int IDX_CLK = 0;
  localparam int IDX_LD  = 1;
  localparam int IDX_OE  = 2;

  logic [2:0] rise, fall;
  diagState_t st, nxt;

  ledDiagEdge #(.N(3), .RST_VAL(3'b100)) u_edge (
    .clk (clk),
    .rstN(rstN),
    .sig ({outEnN, loadStrobe, serClk}),
    .rise(rise),
    .fall(fall)
  );

  always_comb begin
    nxt  = st;
    strb = '0;
    case (st)
      ST_IDLE: begin
        if (rise[IDX_LD] && outEnN) begin
          nxt = ST_SEL;
          strb.enterErr = 1'b1;
        end else begin
          if (rise[IDX_LD]) strb.latch = 1'b1;
          if (rise[IDX_CLK] && loadStrobe && !outEnN) begin
            if (serIn) strb.wakeReq = 1'b1;
            else       strb.shutReq = 1'b1;
          end
        end
      end
      ST_SEL: begin
        if (rise[IDX_CLK] && loadStrobe) strb.pulse = 1'b1;
        if (fall[IDX_LD]) nxt = lcSelected ? ST_LC_ARM : ST_HOLD;
      end
      ST_HOLD: begin
        if (rise[IDX_LD] && outEnN) begin
          nxt = ST_SEL;
          strb.enterErr = 1'b1;
        end else if (!outEnN) begin
          nxt = ST_IDLE;
          strb.leaveErr = 1'b1;
        end
      end
      ST_LC_ARM: begin
        if (rise[IDX_LD]) begin
          nxt = ST_LC_RUN;
          strb.patLoad = 1'b1;
        end
      end
      ST_LC_RUN: begin
        if (rise[IDX_OE]) begin
          nxt = ST_IDLE;
          strb.leaveErr = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  assign errActive  = (st != ST_IDLE);
  assign lowCurrent = (st == ST_LC_RUN) && !outEnN;

  // R2
  lc_arm_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_LC_ARM) |-> lcSelected);

  // R7
  lc_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_LC_RUN && rise[IDX_OE]) |=> !errActive);

  // R1
  enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE && rise[IDX_LD] && outEnN) |=> (errActive && !lcSelected));

endmodule

// File: rtl/ledDiagDpath.sv
module ledDiagDpath
  import ledDiagPkg::*;
#(
  parameter int PULSE_MAX = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strb,
  input  logic        errActive,
  input  logic        serIn,
  input  logic        localFault,
  input  logic        outEnN,
  output logic        lcSelected,
  output logic        openSel,
  output logic        shortSel,
  output logic        lowCurSel,
  output logic        chainOut,
  output logic        dataLatch,
  output logic        patternLoad,
  output logic        driveEn,
  output logic        shutdown
);

  localparam int CNT_W = $clog2(PULSE_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PULSE_MAX);

  logic [CNT_W-1:0] cnt;
  logic [PULSE_MAX:0] selVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.enterErr || strb.leaveErr) begin
      cnt <= '0;
    end else if (strb.pulse && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  for (genvar g = 0; g <= PULSE_MAX; g++) begin : gSel
    assign selVec[g] = errActive && (cnt == CNT_W'(g));
  end

  assign openSel    = selVec[1];
  assign shortSel   = selVec[2];
  assign lowCurSel  = selVec[PULSE_MAX];
  assign lcSelected = (cnt == CNT_MAX);
  assign chainOut   = selVec[0] ? (serIn & ~localFault) : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shutdown    <= 1'b0;
      dataLatch   <= 1'b0;
      patternLoad <= 1'b0;
    end else begin
      if (strb.shutReq)      shutdown <= 1'b1;
      else if (strb.wakeReq) shutdown <= 1'b0;
      dataLatch   <= strb.latch & ~shutdown;
      patternLoad <= strb.patLoad;
    end
  end

  assign driveEn = ~outEnN & ~shutdown;

  // R2
  pulse_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pulse && cnt == CNT_MAX && !strb.enterErr && !strb.leaveErr) |=> (cnt == CNT_MAX));

  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({openSel, shortSel, lowCurSel}));

  // R8
  shut_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shutReq |=> shutdown);

  // R8
  wake_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wakeReq |=> !shutdown);

  // R6
  pat_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    patternLoad |=> !patternLoad);

endmodule

// File: rtl/ledDiagSeq.sv
module ledDiagSeq
  import ledDiagPkg::*;
#(
  parameter int PULSE_MAX = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic serClk,
  input  logic loadStrobe,
  input  logic outEnN,
  input  logic serIn,
  input  logic localFault,
  output logic errActive,
  output logic openSel,
  output logic shortSel,
  output logic lowCurSel,
  output logic lowCurrent,
  output logic patternLoad,
  output logic chainOut,
  output logic dataLatch,
  output logic driveEn,
  output logic shutdown
);

  ctrlStrobe_t strb;
  logic lcSelected;

  ledDiagCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .serClk    (serClk),
    .loadStrobe(loadStrobe),
    .outEnN    (outEnN),
    .serIn     (serIn),
    .lcSelected(lcSelected),
    .strb      (strb),
    .errActive (errActive),
    .lowCurrent(lowCurrent)
  );

  ledDiagDpath #(.PULSE_MAX(PULSE_MAX)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .errActive  (errActive),
    .serIn      (serIn),
    .localFault (localFault),
    .outEnN     (outEnN),
    .lcSelected (lcSelected),
    .openSel    (openSel),
    .shortSel   (shortSel),
    .lowCurSel  (lowCurSel),
    .chainOut   (chainOut),
    .dataLatch  (dataLatch),
    .patternLoad(patternLoad),
    .driveEn    (driveEn),
    .shutdown   (shutdown)
  );

endmodule

// File: tb/ledDiagSeq_bench.sv
`timescale 1ns/1ps
module ledDiagSeq_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, loadStrobe = 1'b0, outEnN = 1'b1, serIn = 1'b1, localFault = 1'b0;
  logic errActive, openSel, shortSel, lowCurSel, lowCurrent, patternLoad;
  logic chainOut, dataLatch, driveEn, shutdown;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string req;
    string name;
    int    id;
    logic  exp;
  } sbItem_t;

  sbItem_t sbq[$];

  always #2.5 clk = ~clk;

  ledDiagSeq u_ledDiagSeq (
    .clk(clk), .rstN(rstN), .serClk(serClk), .loadStrobe(loadStrobe),
    .outEnN(outEnN), .serIn(serIn), .localFault(localFault),
    .errActive(errActive), .openSel(openSel), .shortSel(shortSel),
    .lowCurSel(lowCurSel), .lowCurrent(lowCurrent), .patternLoad(patternLoad),
    .chainOut(chainOut), .dataLatch(dataLatch), .driveEn(driveEn),
    .shutdown(shutdown)
  );

  function automatic logic obs(int id);
    case (id)
      0: return errActive;
      1: return openSel;
      2: return shortSel;
      3: return lowCurSel;
      4: return lowCurrent;
      5: return patternLoad;
      6: return chainOut;
      7: return dataLatch;
      8: return driveEn;
      default: return shutdown;
    endcase
  endfunction

  // monitor: pops expected items and compares against the outputs
  always begin
    wait (sbq.size() != 0);
    begin
      sbItem_t it;
      logic act;
      it = sbq.pop_front();
      act = obs(it.id);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s %s: actual %b expected %b", it.req, it.name, act, it.exp);
      end
    end
  end

  task automatic expectOut(string req, string name, int id, logic exp);
    sbItem_t it;
    it.req = req; it.name = name; it.id = id; it.exp = exp;
    sbq.push_back(it);
    #0.1;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clkPulse();
    tick(); serClk = 1'b1;
    tick(); serClk = 1'b0;
    tick();
  endtask

  task automatic selCheck(string req, logic o, logic s, logic l);
    expectOut(req, "openSel", 1, o);
    expectOut(req, "shortSel", 2, s);
    expectOut(req, "lowCurSel", 3, l);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // reset state: R1 R3 R4 R9
    expectOut("R1", "errActive", 0, 1'b0);
    selCheck("R3", 1'b0, 1'b0, 1'b0);
    expectOut("R4", "chainOut", 6, 1'b1);
    expectOut("R9", "driveEn", 8, 1'b0);
    expectOut("R8", "shutdown", 9, 1'b0);

    // R1 entry into diagnosis operation
    loadStrobe = 1'b1; tick(); tick();
    expectOut("R1", "errActive", 0, 1'b1);
    selCheck("R1", 1'b0, 1'b0, 1'b0);
    // R4 global chain flag
    expectOut("R4", "chainOut", 6, 1'b1);
    localFault = 1'b1; #0.5;
    expectOut("R4", "chainOut", 6, 1'b0);
    localFault = 1'b0; serIn = 1'b0; #0.5;
    expectOut("R4", "chainOut", 6, 1'b0);
    serIn = 1'b1; #0.5;

    // R2 one pulse: open report
    clkPulse();
    selCheck("R2", 1'b1, 1'b0, 1'b0);
    serIn = 1'b0; #0.5;
    expectOut("R4", "chainOut", 6, 1'b1);
    serIn = 1'b1;
    tick(); loadStrobe = 1'b0; tick(); tick();
    expectOut("R5", "errActive", 0, 1'b1);
    expectOut("R2", "openSel", 1, 1'b1);
    // R5 exit with outEnN low
    outEnN = 1'b0; tick(); tick();
    expectOut("R5", "errActive", 0, 1'b0);
    selCheck("R5", 1'b0, 1'b0, 1'b0);
    expectOut("R9", "driveEn", 8, 1'b1);
    expectOut("R5", "dataLatch", 7, 1'b0);

    // R2 two pulses: short report
    outEnN = 1'b1; tick();
    loadStrobe = 1'b1; tick(); tick();
    clkPulse(); clkPulse();
    selCheck("R2", 1'b0, 1'b1, 1'b0);
    loadStrobe = 1'b0; tick(); tick();
    outEnN = 1'b0; tick(); tick();
    expectOut("R5", "errActive", 0, 1'b0);
    expectOut("R5", "shortSel", 2, 1'b0);

    // R9 normal data load
    loadStrobe = 1'b1; tick();
    expectOut("R9", "dataLatch", 7, 1'b1);
    tick();
    expectOut("R9", "dataLatch", 7, 1'b0);
    expectOut("R9", "errActive", 0, 1'b0);

    // R8 shutdown command (loadStrobe high, outEnN low)
    serIn = 1'b0; tick();
    clkPulse();
    expectOut("R8", "shutdown", 9, 1'b1);
    expectOut("R9", "driveEn", 8, 1'b0);
    serIn = 1'b1;
    loadStrobe = 1'b0; tick(); tick();
    loadStrobe = 1'b1; tick();
    expectOut("R9", "dataLatch", 7, 1'b0);
    tick();
    expectOut("R9", "dataLatch", 7, 1'b0);
    // R8 wakeup
    clkPulse();
    expectOut("R8", "shutdown", 9, 1'b0);
    expectOut("R9", "driveEn", 8, 1'b1);
    loadStrobe = 1'b0; tick(); tick();

    // R6/R7 reduced-current testing, five pulses saturate at 3
    outEnN = 1'b1; tick();
    loadStrobe = 1'b1; tick(); tick();
    for (int i = 0; i < 5; i++) clkPulse();
    selCheck("R2", 1'b0, 1'b0, 1'b1);
    loadStrobe = 1'b0; tick(); tick();
    expectOut("R6", "patternLoad", 5, 1'b0);
    expectOut("R2", "lowCurSel", 3, 1'b1);
    loadStrobe = 1'b1; tick();
    expectOut("R6", "patternLoad", 5, 1'b1);
    tick();
    expectOut("R6", "patternLoad", 5, 1'b0);
    expectOut("R7", "lowCurrent", 4, 1'b0);
    loadStrobe = 1'b0; tick(); tick();
    outEnN = 1'b0; #0.5;
    expectOut("R7", "lowCurrent", 4, 1'b1);
    tick(); tick();
    expectOut("R7", "lowCurrent", 4, 1'b1);
    outEnN = 1'b1; #0.5;
    expectOut("R7", "lowCurrent", 4, 1'b0);
    tick(); tick();
    expectOut("R7", "errActive", 0, 1'b0);
    expectOut("R3", "lowCurSel", 3, 1'b0);

    tick();
    wait (sbq.size() == 0);
    #0.5;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule